// File: doc/BRIEF.md
# Grant-Steered Crossbar Slice with Repeater Pipeline

This block is one routing slice of a partitioned asymmetric crossbar. It has no arbiter. A remote central arbiter decides, for every output, which input may send. The slice receives all input data streams, broadcast to every slice, and the arbiter's grant word for its own outputs. It then steers the data. Four identical slices, each with its own slice index, cover the full set of outputs of one sub-switch.

Long wires from the arbiter are broken by a parameterized number of repeater register stages, and zero stages is allowed. Data and grants pass through one shared pipeline, so they arrive in the same cycle. Each local output then takes a one-hot select and a valid bit and registers the flit it selects, or an idle flit. Each lane also reports its global output number.

Top module: `xbs_slice`

## Requirements
- R1: While reset is high and in the cycle after it, every `out_vld` bit is 0 and every `out_data` lane is all zeros.
- R2: A change on `in_data`, `gnt_sel` or `gnt_vld` appears at the outputs exactly REP_STAGES+1 clock cycles later, not earlier. Data and grants sampled in the same cycle are always used together.
- R3: When lane k has `gnt_vld[k]`=1 and `gnt_sel[k*N_IN +: N_IN]` has exactly one bit j set, lane k outputs input j's flit `in_data[j*FW +: FW]` with `out_vld[k]`=1.
- R4: When `gnt_vld[k]`=0, lane k outputs an idle flit (`out_vld[k]`=0, data all zeros), whatever its select bits hold.
- R5: When `gnt_vld[k]`=1 but the select of lane k has zero bits or more than one bit set, lane k outputs an idle flit.
- R6: One input may be granted to several lanes in the same cycle, and each of those lanes carries its flit.
- R7: `out_gidx[k*GW +: GW]` equals SLICE_IDX*N_OUT + k, where GW = clog2(N_OUT*N_SLICES).
- R8: Lanes are independent. Different lanes granted to different inputs in the same cycle each carry their own input's flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | N_IN*FW | Broadcast input flits, input j at bits [j*FW +: FW] |
| gnt_sel | input | N_OUT*N_IN | Per-lane one-hot input select, lane k at bits [k*N_IN +: N_IN] |
| gnt_vld | input | N_OUT | Per-lane grant valid |
| out_data | output | N_OUT*FW | Routed flits, lane k at bits [k*FW +: FW] |
| out_vld | output | N_OUT | Per-lane flit valid |
| out_gidx | output | N_OUT*GW | Global output number of each lane |

## Verification
A repeater stage that is dropped, added or misaligned shifts data relative to grants. The bench sees this in the first streamed sequence, where every cycle carries a different input and select pattern. A flit then shows up one cycle early or late, or the wrong input's data appears on a lane. A lane mux that decodes its select wrongly shows on that lane's outputs in the same cycle it should have carried the flit: wrong data, or an unexpected valid on a zero or two-hot select. Reset faults show in the cycle right after reset.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int XBS_N_IN     = 4;
  localparam int XBS_N_OUT    = 8;
  localparam int XBS_N_SLICES = 4;
  localparam int XBS_FW       = 8;
endpackage

// File: rtl/xbs_repeater.sv
module xbs_repeater #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst};
      assign q = d;
    end else begin : g_pipe
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/xbs_out_mux.sv
module xbs_out_mux #(
  parameter int N_IN = 4,
  parameter int FW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_IN*FW-1:0] in_data,
  input  logic [N_IN-1:0]    sel,
  input  logic               vld,
  output logic [FW-1:0]      o_data,
  output logic               o_vld
);
  logic          hit;
  logic [FW-1:0] pick;

  always_comb begin
    hit  = vld && $onehot(sel);
    pick = '0;
    for (int j = 0; j < N_IN; j++)
      if (sel[j]) pick = pick | in_data[j*FW +: FW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld  <= 1'b0;
      o_data <= '0;
    end else begin
      o_vld  <= hit;
      o_data <= hit ? pick : '0;
    end
  end

  p_idle_no_grant_r4: assert property (@(posedge clk) disable iff (rst)
    !vld |=> (!o_vld && o_data == '0));
  p_idle_bad_sel_r5: assert property (@(posedge clk) disable iff (rst)
    (vld && !$onehot(sel)) |=> (!o_vld && o_data == '0));
  p_grant_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (vld && $onehot(sel)) |=> o_vld);
endmodule

// File: rtl/xbs_slice.sv
module xbs_slice
  import xbs_pkg::*;
#(
  parameter int N_IN       = XBS_N_IN,
  parameter int N_OUT      = XBS_N_OUT,
  parameter int N_SLICES   = XBS_N_SLICES,
  parameter int FW         = XBS_FW,
  parameter int REP_STAGES = 2,
  parameter int SLICE_IDX  = 1,
  localparam int GW        = $clog2(N_OUT*N_SLICES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_IN*FW-1:0]    in_data,
  input  logic [N_OUT*N_IN-1:0] gnt_sel,
  input  logic [N_OUT-1:0]      gnt_vld,
  output logic [N_OUT*FW-1:0]   out_data,
  output logic [N_OUT-1:0]      out_vld,
  output logic [N_OUT*GW-1:0]   out_gidx
);
  localparam int DW = N_IN*FW;
  localparam int SW = N_OUT*N_IN;
  localparam int PW = DW + SW + N_OUT;

  logic [PW-1:0]    bundle_in, bundle_out;
  logic [DW-1:0]    r_data;
  logic [SW-1:0]    r_sel;
  logic [N_OUT-1:0] r_vld;

  assign bundle_in = {gnt_vld, gnt_sel, in_data};

  xbs_repeater #(.STAGES(REP_STAGES), .WIDTH(PW)) u_rep (
    .clk (clk),
    .rst (rst),
    .d   (bundle_in),
    .q   (bundle_out)
  );

  assign {r_vld, r_sel, r_data} = bundle_out;

  generate
    for (genvar k = 0; k < N_OUT; k++) begin : g_lane
      xbs_out_mux #(.N_IN(N_IN), .FW(FW)) u_mux (
        .clk     (clk),
        .rst     (rst),
        .in_data (r_data),
        .sel     (r_sel[k*N_IN +: N_IN]),
        .vld     (r_vld[k]),
        .o_data  (out_data[k*FW +: FW]),
        .o_vld   (out_vld[k])
      );
      assign out_gidx[k*GW +: GW] = GW'(SLICE_IDX*N_OUT + k);
    end
  endgenerate

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (out_vld == '0 && out_data == '0));
endmodule

// File: tb/xbs_slice_bench.sv
module xbs_slice_bench;
  localparam int N_IN = 4, N_OUT = 8, N_SL = 4, FW = 8, ST = 2, SIDX = 1;
  localparam int GW = $clog2(N_OUT*N_SL);
  localparam int LAT = ST + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [N_IN*FW-1:0]    in_data = '0;
  logic [N_OUT*N_IN-1:0] gnt_sel = '0;
  logic [N_OUT-1:0]      gnt_vld = '0;
  logic [N_OUT*FW-1:0]   out_data;
  logic [N_OUT-1:0]      out_vld;
  logic [N_OUT*GW-1:0]   out_gidx;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xbs_slice #(.N_IN(N_IN), .N_OUT(N_OUT), .N_SLICES(N_SL), .FW(FW),
              .REP_STAGES(ST), .SLICE_IDX(SIDX)) u_xbs_slice (
    .clk(clk), .rst(rst), .in_data(in_data), .gnt_sel(gnt_sel),
    .gnt_vld(gnt_vld), .out_data(out_data), .out_vld(out_vld), .out_gidx(out_gidx));

  function automatic logic [N_OUT*FW+N_OUT-1:0] model(
      input logic [N_IN*FW-1:0] d, input logic [N_OUT*N_IN-1:0] s,
      input logic [N_OUT-1:0] v);
    logic [N_OUT*FW-1:0] od = '0;
    logic [N_OUT-1:0]    ov = '0;
    for (int k = 0; k < N_OUT; k++) begin
      logic [N_IN-1:0] sk = s[k*N_IN +: N_IN];
      if (v[k] && $countones(sk) == 1) begin
        ov[k] = 1'b1;
        for (int j = 0; j < N_IN; j++)
          if (sk[j]) od[k*FW +: FW] = d[j*FW +: FW];
      end
    end
    return {ov, od};
  endfunction

  task automatic check(string req, logic [N_OUT*FW+N_OUT-1:0] exp);
    n_chk++;
    if ({out_vld, out_data} !== exp) begin
      n_bad++;
      $display("FAIL %s: actual vld=%h data=%h expected vld=%h data=%h", req,
               out_vld, out_data, exp[N_OUT*FW +: N_OUT], exp[N_OUT*FW-1:0]);
    end
  endtask

  task automatic drive(logic [N_IN*FW-1:0] d, logic [N_OUT*N_IN-1:0] s, logic [N_OUT-1:0] v);
    in_data = d; gnt_sel = s; gnt_vld = v;
  endtask

  // One-shot stimulus; checks not-early (R2) then the routed result.
  task automatic shot(string req, logic [N_IN*FW-1:0] d, logic [N_OUT*N_IN-1:0] s,
                      logic [N_OUT-1:0] v);
    @(negedge clk); drive(d, s, v);
    @(negedge clk); drive('0, '0, '0);
    repeat (LAT-2) @(negedge clk);
    check("R2 not early", '0);
    @(negedge clk);
    check(req, model(d, s, v));
  endtask

  task automatic t_reset;
    drive(32'hDEADBEEF, '1, '1);
    repeat (3) @(negedge clk);
    check("R1 in reset", '0);
    @(negedge clk); drive('0, '0, '0); rst = 1'b0;
    check("R1 after reset", '0);
    for (int k = 0; k < N_OUT; k++) begin
      n_chk++;
      if (out_gidx[k*GW +: GW] !== GW'(SIDX*N_OUT + k)) begin
        n_bad++;
        $display("FAIL R7: lane %0d actual %0d expected %0d", k,
                 out_gidx[k*GW +: GW], SIDX*N_OUT + k);
      end
    end
  endtask

  task automatic t_single;
    for (int j = 0; j < N_IN; j++) begin
      logic [N_OUT*N_IN-1:0] s = '0;
      s[(j+2)*N_IN + j] = 1'b1;
      shot("R3 single grant", 32'hA1B2C3D4 ^ (j * 32'h01010101), s, 8'b1 << (j+2));
    end
  endtask

  task automatic t_idle;
    shot("R4 valid low", 32'h11223344, {N_OUT{4'b0100}}, 8'h00);
  endtask

  task automatic t_bad_sel;
    shot("R5 zero/two-hot select", 32'h55667788,
         {4'b0000, 4'b0011, 4'b1100, 4'b1111, 4'b0000, 4'b0101, 4'b0001, 4'b0000}, 8'hFF);
  endtask

  task automatic t_multicast;
    shot("R6 multicast", 32'h9ABCDEF0, {N_OUT{4'b0010}}, 8'hFF);
  endtask

  task automatic t_stream;
    logic [N_IN*FW-1:0]    sd [6];
    logic [N_OUT*N_IN-1:0] ss [6];
    logic [N_OUT-1:0]      sv [6];
    for (int i = 0; i < 6; i++) begin
      sd[i] = 32'h10203040 + i * 32'h11131719;
      for (int k = 0; k < N_OUT; k++) ss[i][k*N_IN +: N_IN] = 4'b1 << ((k + i) % N_IN);
      sv[i] = 8'hFF ^ (8'h1 << i);
    end
    for (int c = 0; c < 6 + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) check("R2/R8 streamed alignment", model(sd[c-LAT], ss[c-LAT], sv[c-LAT]));
      if (c < 6) drive(sd[c], ss[c], sv[c]); else drive('0, '0, '0);
    end
  endtask

  initial begin
    t_reset;
    t_single;
    t_idle;
    t_bad_sel;
    t_multicast;
    t_stream;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule